// File: doc/BRIEF.md
# Multi-Channel PWM Timer Bank

This block generates several pulse-width-modulated outputs from one shared time base. An input clock feeds a programmable prescaler. Each prescaler tick advances a counter. A bank of compare values sets the shared period and the edge positions of each output, so every output repeats at the same rate. Each output is either single-edge, meaning it is raised at the start of every period and dropped at its own compare value, or double-edge, meaning it is raised at the previous compare value and dropped at its own. With double-edge control, pulses can go positive or negative.

Software writes all settings through one write port. Compare values written while PWM mode runs are held in shadow registers. They reach the comparators only when software sets the matching release bit, and then only at the next period boundary, so an output never shows a pulse mixed from old and new settings. When PWM mode is off, the counter runs as a free timer, the outputs are low, and shadow values pass straight to the comparators.

Write addresses: 0 is control (bit0 run, bit1 PWM mode, bit2 hold), 1 is the prescale limit, 2 is edge mode (bit n set makes output n double-edge), 3 is release (bit i releases compare i), and 4+i is compare i.

Top module: `pwm_timer_bank`

## Requirements
- R1: The prescaler counts clocks from 0 up to its limit (address 1) and then produces one counter tick. With limit L, the counter advances once every L+1 clocks.
- R2: In PWM mode the counter runs 0, 1, ..., compare 0. On the tick after it reaches compare 0 it goes back to zero, so one period lasts compare 0 + 1 ticks.
- R3: A single-edge output n is high while the counter is below compare n. A compare of 0 keeps it low for the whole period. A compare above compare 0 keeps it high for the whole period.
- R4: A double-edge output n (n >= 2, edge-mode bit n = 1) is raised at compare n-1 and dropped at compare n. When compare n-1 < compare n it is high on [compare n-1, compare n). When compare n-1 > compare n it is high outside [compare n, compare n-1). When the two are equal it stays low. Edge-mode bit 1 is ignored, so output 1 is always single-edge.
- R5: In PWM mode, writing a compare value does not change any output until software sets release bit i (address 3, bit i for compare i) and the counter wraps.
- R6: The hardware clears the release bits when they are applied. A compare written after that needs a new release.
- R7: A release written in the same clock as a wrap is applied at the following wrap, not at that one.
- R8: With PWM mode off, the counter runs past compare 0 without wrapping, all outputs are low, and compare writes reach the comparators without a release.
- R9: Control bit0 enables counting and bit2 holds both the counter and the prescaler at zero.
- R10: After reset the counter reads zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Register write data |
| tc_value | output | CNT_W | Current counter value |
| pwm_out | output | NUM_MATCH-1 | PWM outputs; bit j is output j+1 |

## Verification
A software release and the period wrap can land in the same clock. The wrap then applies whichever release bits were already set, and the new write arms the release bits again. The bench provokes this by waiting for the counter to read compare 0 and issuing the release write on that clock edge. It then checks two whole periods. The first must still show the old waveform, and the second must show the new one. A shadow compare written one period earlier stays pending throughout, so applying it too early shows up as a wrong output bit.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  // register addresses on the write port
  localparam int ADDR_CTRL     = 0;
  localparam int ADDR_PRESCALE = 1;
  localparam int ADDR_EDGE     = 2;
  localparam int ADDR_RELEASE  = 3;
  localparam int MATCH_BASE    = 4;

  // control word, bit2 hold, bit1 pwm mode, bit0 run
  typedef struct packed {
    logic hold;
    logic pwm;
    logic run;
  } ctrl_t;

  localparam int CTRL_BITS = $bits(ctrl_t);

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PRE_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic [PRE_W-1:0] limit,
  output logic             tick
);

  logic [PRE_W-1:0] pc_q, pc_n;
  logic             tick_c;

  always_comb begin
    tick_c = run && !hold && (pc_q >= limit);
    pc_n   = pc_q;
    if (hold) begin
      pc_n = '0;
    end else if (run) begin
      pc_n = tick_c ? '0 : pc_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_n;
    end
  end

  assign tick = tick_c;

endmodule

// File: rtl/pwm_match_bank.sv
module pwm_match_bank
  import pwm_timer_pkg::*;
#(
  parameter int NUM_MATCH = 4,
  parameter int CNT_W     = 32,
  parameter int ADDR_W    = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [CNT_W-1:0]                 wr_data,
  input  logic                             pwm_mode,
  input  logic                             apply,
  output logic [NUM_MATCH-1:0][CNT_W-1:0]  act_q,
  output logic [NUM_MATCH-1:0][CNT_W-1:0]  act_n,
  output logic [NUM_MATCH-1:0]             le_q
);

  logic [NUM_MATCH-1:0][CNT_W-1:0] shadow_q, shadow_n;
  logic [NUM_MATCH-1:0]            le_n;
  logic [NUM_MATCH-1:0]            sel_match;
  logic                            sel_release;

  assign sel_release = wr_en && (wr_addr == ADDR_W'(ADDR_RELEASE));

  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_slot
    assign sel_match[i] = wr_en && (wr_addr == ADDR_W'(MATCH_BASE + i));

    always_comb begin
      shadow_n[i] = sel_match[i] ? wr_data : shadow_q[i];
      if (!pwm_mode) begin
        act_n[i] = shadow_q[i];
      end else if (apply && le_q[i]) begin
        act_n[i] = shadow_q[i];
      end else begin
        act_n[i] = act_q[i];
      end
    end
  end

  always_comb begin
    le_n = apply ? '0 : le_q;
    if (sel_release) begin
      le_n = le_n | wr_data[NUM_MATCH-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      act_q    <= '0;
      le_q     <= '0;
    end else begin
      shadow_q <= shadow_n;
      act_q    <= act_n;
      le_q     <= le_n;
    end
  end

endmodule

// File: rtl/pwm_edge_unit.sv
module pwm_edge_unit #(
  parameter int CNT_W = 32
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] m_set,
  input  logic [CNT_W-1:0] m_clr,
  input  logic             dbl,
  output logic             level
);

  always_comb begin
    if (!dbl) begin
      level = (cnt < m_clr);
    end else if (m_set <= m_clr) begin
      level = (cnt >= m_set) && (cnt < m_clr);
    end else begin
      level = (cnt >= m_set) || (cnt < m_clr);
    end
  end

endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
  import pwm_timer_pkg::*;
#(
  parameter  int NUM_MATCH = 4,
  parameter  int CNT_W     = 32,
  parameter  int PRE_W     = 32,
  localparam int NUM_OUT   = NUM_MATCH - 1,
  localparam int ADDR_W    = $clog2(MATCH_BASE + NUM_MATCH),
  localparam int DATA_W    = (CNT_W > PRE_W) ? CNT_W : PRE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [CNT_W-1:0]   tc_value,
  output logic [NUM_OUT-1:0] pwm_out
);

  // reset synchroniser
  logic rst_meta_q, rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  // configuration registers
  logic sel_ctrl, sel_pre, sel_edge;
  ctrl_t                ctrl_q, ctrl_n;
  logic [PRE_W-1:0]     pre_lim_q, pre_lim_n;
  logic [NUM_OUT:2]     dbl_q, dbl_n;

  assign sel_ctrl = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
  assign sel_pre  = wr_en && (wr_addr == ADDR_W'(ADDR_PRESCALE));
  assign sel_edge = wr_en && (wr_addr == ADDR_W'(ADDR_EDGE));

  always_comb begin
    ctrl_n    = sel_ctrl ? ctrl_t'(wr_data[CTRL_BITS-1:0]) : ctrl_q;
    pre_lim_n = sel_pre  ? wr_data[PRE_W-1:0] : pre_lim_q;
    dbl_n     = sel_edge ? wr_data[NUM_OUT:2] : dbl_q;
  end

  // prescaler
  logic tick;

  pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_q),
    .run   (ctrl_q.run),
    .hold  (ctrl_q.hold),
    .limit (pre_lim_q),
    .tick  (tick)
  );

  // compare bank
  logic [NUM_MATCH-1:0][CNT_W-1:0] act_q, act_n;
  logic [NUM_MATCH-1:0]            le_q;
  logic                            wrap;
  logic [CNT_W-1:0]                tc_q, tc_n;

  assign wrap = tick && ctrl_q.pwm && (tc_q >= act_q[0]);

  pwm_match_bank #(
    .NUM_MATCH (NUM_MATCH),
    .CNT_W     (CNT_W),
    .ADDR_W    (ADDR_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_q),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data[CNT_W-1:0]),
    .pwm_mode (ctrl_q.pwm),
    .apply    (wrap),
    .act_q    (act_q),
    .act_n    (act_n),
    .le_q     (le_q)
  );

  // counter next state
  always_comb begin
    tc_n = tc_q;
    if (ctrl_q.hold) begin
      tc_n = '0;
    end else if (tick) begin
      tc_n = wrap ? '0 : tc_q + CNT_W'(1);
    end
  end

  // per-output edge logic evaluated on next state
  logic [NUM_OUT-1:0] lvl_n, out_n, out_q;

  for (genvar n = 1; n <= NUM_OUT; n++) begin : g_out
    logic dbl_sel;
    if (n == 1) begin : g_first
      assign dbl_sel = 1'b0;
    end else begin : g_rest
      assign dbl_sel = dbl_n[n];
    end

    pwm_edge_unit #(.CNT_W(CNT_W)) u_edge (
      .cnt   (tc_n),
      .m_set (act_n[n-1]),
      .m_clr (act_n[n]),
      .dbl   (dbl_sel),
      .level (lvl_n[n-1])
    );
  end

  assign out_n = ctrl_n.pwm ? lvl_n : '0;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ctrl_q    <= '0;
      pre_lim_q <= '0;
      dbl_q     <= '0;
      tc_q      <= '0;
      out_q     <= '0;
    end else begin
      ctrl_q    <= ctrl_n;
      pre_lim_q <= pre_lim_n;
      dbl_q     <= dbl_n;
      tc_q      <= tc_n;
      out_q     <= out_n;
    end
  end

  assign tc_value = tc_q;
  assign pwm_out  = out_q;

endmodule

// File: rtl/pwm_timer_bank_chk.sv
module pwm_timer_bank_chk
  import pwm_timer_pkg::*;
#(
  parameter  int NUM_MATCH = 4,
  parameter  int CNT_W     = 32,
  parameter  int ADDR_W    = 3,
  localparam int NUM_OUT   = NUM_MATCH - 1
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            wr_en,
  input logic [ADDR_W-1:0]               wr_addr,
  input logic                            tick,
  input logic                            wrap,
  input logic                            hold,
  input logic                            pwm,
  input logic [CNT_W-1:0]                tc_value,
  input logic [NUM_OUT-1:0]              pwm_out,
  input logic [NUM_MATCH-1:0][CNT_W-1:0] act_q,
  input logic [NUM_MATCH-1:0]            le_q
);

  logic wr_release;
  assign wr_release = wr_en && (wr_addr == ADDR_W'(ADDR_RELEASE));

  // R1: without a tick and without hold the counter keeps its value
  p_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !hold) |=> $stable(tc_value));

  // R2: a tick that is not a wrap advances the counter by one
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap && !hold) |=> (tc_value == $past(tc_value) + CNT_W'(1)));

  // R2: a wrap returns the counter to zero
  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (tc_value == '0));

  // R3: a zero compare keeps output 1 low in pwm mode
  p_zero_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && (act_q[1] == '0)) |-> !pwm_out[0]);

  // R5: active compares change only at a wrap in pwm mode
  p_act_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !wrap) |=> $stable(act_q));

  // R6: release bits are cleared once applied
  p_release_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !wr_release) |=> (le_q == '0));

  // R8: outputs stay low in timer mode
  p_timer_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm |-> (pwm_out == '0));

  // R9: hold forces the counter to zero
  p_hold_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (tc_value == '0));

endmodule

bind pwm_timer_bank pwm_timer_bank_chk #(
  .NUM_MATCH (NUM_MATCH),
  .CNT_W     (CNT_W),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_q),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .tick     (tick),
  .wrap     (wrap),
  .hold     (ctrl_q.hold),
  .pwm      (ctrl_q.pwm),
  .tc_value (tc_value),
  .pwm_out  (pwm_out),
  .act_q    (act_q),
  .le_q     (le_q)
);

// File: tb/pwm_timer_bank_tb_top.sv
`timescale 1ns/1ps
module pwm_timer_bank_tb_top;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_PRE  = 3'd1;
  localparam logic [2:0] A_EDGE = 3'd2;
  localparam logic [2:0] A_REL  = 3'd3;
  localparam logic [2:0] A_M0   = 3'd4;

  // {edge mode[3:0], m0, m1, m2, m3, mask out1, mask out2, mask out3}; mask bit k = level at count k
  localparam logic [59:0] VECS [4] = '{
    {4'b0000, 8'd7, 8'd3, 8'd0, 8'd9, 8'h07, 8'h00, 8'hFF},
    {4'b1100, 8'd7, 8'd2, 8'd5, 8'd6, 8'h03, 8'h1C, 8'h20},
    {4'b1000, 8'd7, 8'd7, 8'd6, 8'd2, 8'h7F, 8'h3F, 8'hC3},
    {4'b0110, 8'd7, 8'd4, 8'd4, 8'd8, 8'h0F, 8'h00, 8'hFF}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic [31:0] tc_value;
  logic [2:0]  pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_timer_bank dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .tc_value (tc_value),
    .pwm_out  (pwm_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_tc(input logic [31:0] v, input bit eq);
    int n = 0;
    while (((tc_value == v) != eq) && (n < 64)) begin
      @(negedge clk);
      n++;
    end
    if (n >= 64) check("R2 wait for count", tc_value, v);
  endtask

  task automatic check_period(input logic [7:0] e1, input logic [7:0] e2,
                              input logic [7:0] e3, input bit skip, input string req);
    if (skip) begin
      wait_tc(32'd0, 1'b0);
      wait_tc(32'd0, 1'b1);
    end
    for (int k = 0; k < 8; k++) begin
      check("R2 count sequence", tc_value, k);
      check(req, {29'd0, pwm_out}, {29'd0, e3[k], e2[k], e1[k]});
      @(negedge clk);
    end
  endtask

  // timer mode with hold: compares reach comparators directly (R8)
  task automatic load_cfg(input logic [3:0] dbl, input logic [7:0] m0, input logic [7:0] m1,
                          input logic [7:0] m2, input logic [7:0] m3);
    wr(A_CTRL, 32'd4);
    wr(A_EDGE, {28'd0, dbl});
    wr(A_M0,        {24'd0, m0});
    wr(A_M0 + 3'd1, {24'd0, m1});
    wr(A_M0 + 3'd2, {24'd0, m2});
    wr(A_M0 + 3'd3, {24'd0, m3});
    wr(A_CTRL, 32'd3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired, actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state
    check("R10 counter after reset", tc_value, 32'd0);
    check("R10 outputs after reset", {29'd0, pwm_out}, 32'd0);

    // R3, R4, R8: vector table, each loaded in timer mode then run one period
    for (int v = 0; v < 4; v++) begin
      load_cfg(VECS[v][59:56], VECS[v][55:48], VECS[v][47:40], VECS[v][39:32], VECS[v][31:24]);
      check_period(VECS[v][23:16], VECS[v][15:8], VECS[v][7:0], 1'b0, "R3,R4 waveform");
    end

    // R5: shadow write without release leaves waveform unchanged
    load_cfg(4'b0000, 8'd7, 8'd3, 8'd5, 8'd9);
    check_period(8'h07, 8'h1F, 8'hFF, 1'b0, "R3 baseline");
    wr(A_M0 + 3'd1, 32'd6);
    check_period(8'h07, 8'h1F, 8'hFF, 1'b1, "R5 unreleased shadow");
    wr(A_REL, 32'b0010);
    check_period(8'h3F, 8'h1F, 8'hFF, 1'b1, "R5 released at wrap");

    // R6: release bit consumed, later shadow write stays pending
    wr(A_M0 + 3'd1, 32'd2);
    check_period(8'h3F, 8'h1F, 8'hFF, 1'b1, "R6 release cleared");

    // R7: release written in the wrap clock takes effect one period later
    wait_tc(32'd7, 1'b1);
    wr(A_REL, 32'b0010);
    check_period(8'h3F, 8'h1F, 8'hFF, 1'b0, "R7 period after collision");
    check_period(8'h03, 8'h1F, 8'hFF, 1'b0, "R7 following period");

    // R8: timer mode runs past compare 0, outputs low
    wr(A_CTRL, 32'd4);
    wr(A_M0, 32'd5);
    wr(A_CTRL, 32'd1);
    repeat (20) @(posedge clk);
    @(negedge clk);
    check("R8 free-running count", tc_value, 32'd20);
    check("R8 outputs low", {29'd0, pwm_out}, 32'd0);

    // R1: prescale limit 3 gives one tick per four clocks
    wr(A_CTRL, 32'd4);
    wr(A_PRE, 32'd3);
    wr(A_CTRL, 32'd1);
    repeat (40) @(posedge clk);
    @(negedge clk);
    check("R1 prescaled count", tc_value, 32'd10);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 count between ticks", tc_value, 32'd10);
    @(posedge clk);
    @(negedge clk);
    check("R1 count at next tick", tc_value, 32'd11);

    // R9: hold keeps counter at zero while run is set
    wr(A_CTRL, 32'd5);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R9 hold keeps zero", tc_value, 32'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 hold still zero", tc_value, 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule